// File: doc/BRIEF.md
# Writeback Hazard Queue

This block is an in-order queue of writebacks that have not yet reached the register file. The execute stage pushes one record per issued instruction. The writeback stage reads the oldest record at the head and pops it once the write is done. Each record has a kind. An ALU result carries a destination register and 32 bits of data. A load carries only a destination register, because its data comes later from memory. Stores and host writes carry no destination.

Two combinational lookup ports take a 5-bit register index each. A port raises its hit output when any occupied entry holds an ALU result or a load aimed at that register. The execute stage checks both source operands of an instruction in the same cycle and stalls on either hit. The lookups see the queue as it stands at the start of the cycle. A record leaving in this cycle still hits, and a record arriving in this cycle does not hit yet. A synchronous clear drops every entry at once, for example after a redirect.

Top module: `wb_hazard_queue`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, and both hit outputs are 0.
- R2: Record kind codes are 0 for an ALU result (destination and data), 1 for a load (destination), 2 for a store and 3 for a host write. The head outputs show the kind, destination and data of the oldest record, and records leave strictly in the order they were accepted.
- R3: A lookup port hits exactly when some occupied entry of kind 0 or 1 has a destination equal to the queried index.
- R4: Entries of kind 2 or 3 never cause a hit, whatever value their destination field holds.
- R5: The two lookup ports are independent. In the same cycle each reports its own index.
- R6: A slot that has been dequeued or cleared never causes a hit, even though its stale contents remain.
- R7: Lookups use the contents from before the clock edge. An entry dequeued in the current cycle still hits, and an entry enqueued in the current cycle does not.
- R8: full_o is 1 while DEPTH records are held. An enqueue while full, without a dequeue in the same cycle, is refused and leaves the contents unchanged. full_o and empty_o are never 1 together.
- R9: A dequeue while empty is ignored. While empty, the head outputs read as zero.
- R10: While full, an enqueue together with a dequeue is accepted. The queue stays full and the new record goes to the tail.
- R11: clr_i empties the queue at the next edge and takes priority over an enqueue or dequeue in the same cycle. In the following cycle no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous flush of all entries |
| enq_i | input | 1 | Push a record |
| enq_kind_i | input | 2 | Kind of the pushed record |
| enq_dest_i | input | 5 | Destination register of the pushed record |
| enq_data_i | input | 32 | Result data of the pushed record |
| deq_i | input | 1 | Pop the head record |
| full_o | output | 1 | Queue holds DEPTH records |
| empty_o | output | 1 | Queue holds no record |
| head_kind_o | output | 2 | Kind of the oldest record |
| head_dest_o | output | 5 | Destination of the oldest record |
| head_data_o | output | 32 | Data of the oldest record |
| srch_a_idx_i | input | 5 | Register index for lookup port A |
| srch_a_hit_o | output | 1 | Port A index is pending a write |
| srch_b_idx_i | input | 5 | Register index for lookup port B |
| srch_b_hit_o | output | 1 | Port B index is pending a write |

## Verification
A wrong occupancy bit shows up at once on the lookup ports. A leftover bit gives a false hit on a register that has already been written, and a lost bit gives a missed hit. Either one differs from the reference model in the same cycle. A pointer or counter error shows up on the head outputs at the next pop, or on full_o and empty_o in the cycle after the edge. Kind filtering errors show up as a hit on a store or host destination field in the cycle after that record is accepted.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  localparam int REG_IDX_W = 5;
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {
    REC_ALU   = 2'd0,
    REC_LOAD  = 2'd1,
    REC_STORE = 2'd2,
    REC_HOST  = 2'd3
  } rec_kind_e;

  typedef struct packed {
    rec_kind_e              kind;
    logic [REG_IDX_W-1:0]   dest;
    logic [DATA_W-1:0]      data;
  } wb_rec_t;

  function automatic logic rec_writes_reg(rec_kind_e k);
    return (k == REC_ALU) || (k == REC_LOAD);
  endfunction
endpackage

// File: rtl/wbq_ctrl.sv
module wbq_ctrl #(
  parameter  int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             enq_i,
  input  logic             deq_i,
  output logic             enq_ok_o,
  output logic             deq_ok_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_q, rd_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign deq_ok_o = deq_i && !empty_o && !clr_i;
  // full queue accepts a push only when the head leaves in the same cycle
  assign enq_ok_o = enq_i && !clr_i && (!full_o || deq_ok_o);
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (enq_ok_o) wr_q <= bump(wr_q);
      if (deq_ok_o) rd_q <= bump(rd_q);
      case ({enq_ok_o, deq_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/wbq_slots.sv
module wbq_slots
  import wbq_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  we_i,
  input  logic [PTR_W-1:0]      wr_ptr_i,
  input  wb_rec_t               wr_rec_i,
  input  logic                  re_i,
  input  logic [PTR_W-1:0]      rd_ptr_i,
  output wb_rec_t [DEPTH-1:0]   slots_o,
  output logic    [DEPTH-1:0]   occ_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_wr, hit_rd;
    assign hit_wr = we_i && (wr_ptr_i == PTR_W'(i));
    assign hit_rd = re_i && (rd_ptr_i == PTR_W'(i));

    always_ff @(posedge clk_i) begin
      if (hit_wr) slots_o[i] <= wr_rec_i;
    end

    // refill of the slot being vacated keeps it occupied
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     occ_o[i] <= 1'b0;
      else if (clr_i)  occ_o[i] <= 1'b0;
      else if (hit_wr) occ_o[i] <= 1'b1;
      else if (hit_rd) occ_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/wbq_search.sv
module wbq_search
  import wbq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  wb_rec_t [DEPTH-1:0]   slots_i,
  input  logic    [DEPTH-1:0]   occ_i,
  input  logic [REG_IDX_W-1:0]  idx_i,
  output logic                  hit_o
);
  logic [DEPTH-1:0] match;
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = occ_i[i] && rec_writes_reg(slots_i[i].kind)
                      && (slots_i[i].dest == idx_i);
  end
  assign hit_o = |match;
endmodule

// File: rtl/wb_hazard_queue.sv
module wb_hazard_queue
  import wbq_pkg::*;
#(
  parameter  int DEPTH  = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NPORTS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        enq_i,
  input  logic [1:0]  enq_kind_i,
  input  logic [4:0]  enq_dest_i,
  input  logic [31:0] enq_data_i,
  input  logic        deq_i,
  output logic        full_o,
  output logic        empty_o,
  output logic [1:0]  head_kind_o,
  output logic [4:0]  head_dest_o,
  output logic [31:0] head_data_o,
  input  logic [4:0]  srch_a_idx_i,
  output logic        srch_a_hit_o,
  input  logic [4:0]  srch_b_idx_i,
  output logic        srch_b_hit_o
);
  logic                  enq_ok, deq_ok;
  logic [PTR_W-1:0]      wr_ptr, rd_ptr;
  wb_rec_t               in_rec, head_rec;
  wb_rec_t [DEPTH-1:0]   slots;
  logic    [DEPTH-1:0]   occ;
  logic [REG_IDX_W-1:0]  idx [NPORTS];
  logic [NPORTS-1:0]     hit;

  assign in_rec = '{kind: rec_kind_e'(enq_kind_i), dest: enq_dest_i, data: enq_data_i};

  wbq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .clr_i, .enq_i, .deq_i,
    .enq_ok_o(enq_ok), .deq_ok_o(deq_ok),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .full_o, .empty_o
  );

  wbq_slots #(.DEPTH(DEPTH)) u_slots (
    .clk_i, .rst_ni, .clr_i,
    .we_i(enq_ok), .wr_ptr_i(wr_ptr), .wr_rec_i(in_rec),
    .re_i(deq_ok), .rd_ptr_i(rd_ptr),
    .slots_o(slots), .occ_o(occ)
  );

  assign idx[0] = srch_a_idx_i;
  assign idx[1] = srch_b_idx_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    wbq_search #(.DEPTH(DEPTH)) u_srch (
      .slots_i(slots), .occ_i(occ), .idx_i(idx[p]), .hit_o(hit[p])
    );
  end

  assign srch_a_hit_o = hit[0];
  assign srch_b_hit_o = hit[1];

  assign head_rec    = empty_o ? '0 : slots[rd_ptr];
  assign head_kind_o = head_rec.kind;
  assign head_dest_o = head_rec.dest;
  assign head_data_o = head_rec.data;
endmodule

// File: rtl/wbq_chk.sv
module wbq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clr_i,
  input logic        enq_i,
  input logic [1:0]  enq_kind_i,
  input logic [31:0] enq_data_i,
  input logic        deq_i,
  input logic        full_o,
  input logic        empty_o,
  input logic [1:0]  head_kind_o,
  input logic [4:0]  head_dest_o,
  input logic [31:0] head_data_o,
  input logic        srch_a_hit_o,
  input logic        srch_b_hit_o
);
  // R8
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R11
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);

  // R6
  empty_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!srch_a_hit_o && !srch_b_hit_o));

  // R8
  refused_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && enq_i && !deq_i && !clr_i) |=>
      (full_o && $stable(head_data_o) && $stable(head_dest_o) && $stable(head_kind_o)));

  // R10
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && enq_i && deq_i && !clr_i) |=> full_o);

  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && deq_i && !enq_i && !clr_i) |=> empty_o);

  // R2
  first_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && enq_i && !clr_i) |=>
      (!empty_o && head_data_o == $past(enq_data_i) && head_kind_o == $past(enq_kind_i)));
endmodule

bind wb_hazard_queue wbq_chk u_chk (
  .clk_i, .rst_ni, .clr_i, .enq_i, .enq_kind_i, .enq_data_i, .deq_i,
  .full_o, .empty_o, .head_kind_o, .head_dest_o, .head_data_o,
  .srch_a_hit_o, .srch_b_hit_o
);

// File: tb/sim_wb_hazard_queue.sv
module sim_wb_hazard_queue;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, enq = 1'b0, deq = 1'b0;
  logic [1:0]  enq_kind = '0;
  logic [4:0]  enq_dest = '0, idx_a = '0, idx_b = '0;
  logic [31:0] enq_data = '0;
  logic        full, empty, hit_a, hit_b;
  logic [1:0]  h_kind;
  logic [4:0]  h_dest;
  logic [31:0] h_data;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic [1:0]  kind;
    logic [4:0]  dest;
    logic [31:0] data;
  } rec_t;
  rec_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  wb_hazard_queue #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .enq_i(enq),
    .enq_kind_i(enq_kind), .enq_dest_i(enq_dest), .enq_data_i(enq_data),
    .deq_i(deq), .full_o(full), .empty_o(empty),
    .head_kind_o(h_kind), .head_dest_o(h_dest), .head_data_o(h_data),
    .srch_a_idx_i(idx_a), .srch_a_hit_o(hit_a),
    .srch_b_idx_i(idx_b), .srch_b_hit_o(hit_b)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic model_hit(logic [4:0] idx);
    foreach (exp_q[i])
      if (exp_q[i].kind < 2 && exp_q[i].dest == idx) return 1'b1;
    return 1'b0;
  endfunction

  // driver: applies one cycle of stimulus, compares against the scoreboard, then updates it
  task automatic step(string req, bit c, bit e, logic [1:0] k, logic [4:0] d,
                      logic [31:0] dat, bit p, logic [4:0] ia, logic [4:0] ib);
    rec_t hd;
    bit   deq_acc, enq_acc;
    @(negedge clk);
    clr = c; enq = e; enq_kind = k; enq_dest = d; enq_data = dat; deq = p;
    idx_a = ia; idx_b = ib;
    #1;
    hd = '{kind: 2'd0, dest: 5'd0, data: 32'd0};
    if (exp_q.size() > 0) hd = exp_q[0];
    check(req, "full",  32'(full),  32'(exp_q.size() == DEPTH));
    check(req, "empty", 32'(empty), 32'(exp_q.size() == 0));
    check(req, "head_kind", 32'(h_kind), 32'(hd.kind));
    check(req, "head_dest", 32'(h_dest), 32'(hd.dest));
    check(req, "head_data", h_data, hd.data);
    check(req, "hit_a", 32'(hit_a), 32'(model_hit(ia)));
    check(req, "hit_b", 32'(hit_b), 32'(model_hit(ib)));
    @(posedge clk);
    if (c) begin
      exp_q.delete();
    end else begin
      deq_acc = p && exp_q.size() > 0;
      enq_acc = e && (exp_q.size() < DEPTH || deq_acc);
      if (deq_acc) void'(exp_q.pop_front());
      if (enq_acc) exp_q.push_back('{kind: k, dest: d, data: dat});
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "empty", 32'(empty), 32'd1);
    check("R1", "full",  32'(full),  32'd0);
    check("R1", "hit_a", 32'(hit_a), 32'd0);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 5'd0, 5'd0);
    // R2 R3 R5: ALU and load records, both ports in one cycle
    step("R2", 0, 1, 2'd0, 5'd3, 32'hAAAA_0003, 0, 5'd3, 5'd9);
    step("R3", 0, 1, 2'd1, 5'd9, 32'h0, 0, 5'd3, 5'd9);
    step("R5", 0, 0, 0, 0, 0, 0, 5'd3, 5'd9);
    step("R5", 0, 0, 0, 0, 0, 0, 5'd4, 5'd9);
    // R4: store and host with destination fields set
    step("R4", 0, 1, 2'd2, 5'd12, 32'h1212, 0, 5'd12, 5'd13);
    step("R4", 0, 1, 2'd3, 5'd13, 32'h1313, 0, 5'd12, 5'd13);
    step("R4", 0, 0, 0, 0, 0, 0, 5'd12, 5'd13);
    // R8: push while full is refused
    step("R8", 0, 1, 2'd0, 5'd20, 32'h2020, 0, 5'd20, 5'd3);
    step("R8", 0, 0, 0, 0, 0, 0, 5'd20, 5'd3);
    // R10: push and pop while full
    step("R10", 0, 1, 2'd0, 5'd21, 32'h2121, 1, 5'd21, 5'd3);
    step("R10", 0, 0, 0, 0, 0, 0, 5'd21, 5'd3);
    // R7: popped entry still hits in its own cycle
    step("R7", 0, 0, 0, 0, 0, 1, 5'd9, 5'd21);
    // R6: freed slot no longer hits
    step("R6", 0, 0, 0, 0, 0, 0, 5'd9, 5'd3);
    // R7: entry pushed this cycle does not hit yet
    step("R7", 0, 1, 2'd0, 5'd22, 32'h2222, 0, 5'd22, 5'd21);
    step("R7", 0, 0, 0, 0, 0, 0, 5'd22, 5'd21);
    // drain, then pop while empty
    for (int i = 0; i < 5; i++) step("R2", 0, 0, 0, 0, 0, 1, 5'd22, 5'd21);
    step("R9", 0, 0, 0, 0, 0, 1, 5'd22, 5'd21);
    step("R9", 0, 0, 0, 0, 0, 0, 5'd0, 5'd21);
    // R11: clear with a concurrent push
    step("R11", 0, 1, 2'd0, 5'd5, 32'h55, 0, 5'd5, 5'd6);
    step("R11", 0, 1, 2'd1, 5'd6, 32'h66, 0, 5'd5, 5'd6);
    step("R11", 1, 1, 2'd0, 5'd7, 32'h77, 1, 5'd5, 5'd6);
    step("R11", 0, 0, 0, 0, 0, 0, 5'd5, 5'd7);
    // mixed traffic
    for (int i = 0; i < 600; i++)
      step("R3", ($urandom_range(0, 40) == 0), $urandom_range(0, 1),
           2'($urandom_range(0, 3)), 5'($urandom_range(0, 7)), $urandom,
           $urandom_range(0, 1), 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule